// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test-port controller of a device's boundary-scan logic. It steps the standard sixteen-state test-port state machine on the rising edge of the test clock, as the mode-select line directs. It holds a four-bit instruction register and decodes five instructions. The decoded instruction picks the data path that sits between the serial input and the serial output. That path is one of three: a one-bit bypass stage, a 32-bit identification register, or the external boundary-cell chain. The controller also sends capture, shift and update strobes to that chain, along with two pad-control flags. One flag tells the pads to drive from the chain's update latches. The other tells every input and I/O driver to go high impedance.

No separate test-reset pin exists. The controller reaches Test-Logic-Reset in only two ways: a power-on reset input, or five rising clock edges with the mode-select line high. A disable input turns the test port off. While it is high, the four port pins are released for ordinary use and the controller is held in reset. The serial output changes on the falling clock edge. It is enabled only while an instruction or a data register is being shifted. The pad driver outside the block uses the enable to float the pin at all other times.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `por` is high, the controller is in Test-Logic-Reset. After a falling clock edge in that state, `tdo_en`, `pins_hiz` and `extest_mode` are low and the identification instruction is active. A data scan that follows therefore returns the ID word.
- R2: From any state, five rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset. This makes the identification instruction active and clears any high-impedance instruction.
- R3: On entry to Capture-IR the instruction shift register loads binary 0001. Shift-IR moves it out on `tdo` least significant bit first, so the first four bits of every instruction scan are 1,0,0,0.
- R4: Under the identification instruction (code 0010), Capture-DR loads the 32-bit `ID_VALUE` with its bit 0 forced to 1. The word leaves least significant bit first, and bits from `tdi` follow it after 32 shifts.
- R5: Under code 1111 the data path is a single stage that captures 0. A data scan returns 0 and then the `tdi` stream delayed by one bit.
- R6: Every code other than 0000, 0001, 0010 and 0011 behaves exactly like code 1111.
- R7: Code 0011 sets `pins_hiz` high and uses the one-bit bypass stage as its data path. No chain strobe fires while it is active.
- R8: Codes 0001 (sample) and 0000 (external test) place the boundary chain between `tdi` and `tdo`, with `bsr_so` as the chain's last cell. `extest_mode` is high only under code 0000.
- R9: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only under a chain instruction. At most one is high at a time, so each data scan gives exactly one update.
- R10: `tdo` changes only on falling `tck` edges. `tdo_en` is high only during the falling-edge intervals spent in Shift-IR or Shift-DR, one interval per shifted bit.
- R11: While `jtag_off` is high, `pins_released` is high, the controller is held in reset with `tdo_en`, `pins_hiz` and `extest_mode` low, and `tms` is ignored.
- R12: A newly shifted instruction takes effect on the falling `tck` edge while in Update-IR, not on the rising edge that enters Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, sampled on rising `tck` |
| jtag_off | input | 1 | Test port disable; holds the controller in reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out, updated on falling `tck` |
| tdo_en | output | 1 | Output-driver enable for `tdo`; low means high impedance |
| bsr_so | input | 1 | Serial output of the external boundary-cell chain |
| bsr_capture | output | 1 | Chain capture strobe |
| bsr_shift | output | 1 | Chain shift strobe |
| bsr_update | output | 1 | Chain update strobe |
| extest_mode | output | 1 | Pads driven from the chain update latches |
| pins_hiz | output | 1 | Force every input and I/O driver to high impedance |
| pins_released | output | 1 | The four port pins are free for general use |

## Verification
The embedded properties watch the cycle-level relations on every clock. Five rising edges with mode-select high always leave the controller in Test-Logic-Reset. Capture-IR and the bypass capture always load their fixed values. The output enable never rises outside a shift state. At most one chain strobe fires at a time, and none fires under high-impedance mode. The active instruction changes only in Update-IR or reset. Only the bench's scans can show the full serial behaviour: the bit order of the ID word and the bypass delay, the mapping of unused codes to bypass, and the chain data passing through under sample and external test. They also show that the disable input really holds off all pin control until the port is released.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] CODE_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] CODE_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] CODE_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] CODE_HIGHZ   = 4'b0011;
    localparam logic [IR_W-1:0] CODE_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        OP_EXTEST, OP_SAMPLE, OP_IDCODE, OP_HIGHZ, OP_BYPASS
    } tap_op_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } chain_ctl_t;

    // Standard test-port transition table
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    // Unlisted codes fall through to bypass
    function automatic tap_op_e decode_op(input logic [IR_W-1:0] code);
        tap_op_e op;
        case (code)
            CODE_EXTEST: op = OP_EXTEST;
            CODE_SAMPLE: op = OP_SAMPLE;
            CODE_IDCODE: op = OP_IDCODE;
            CODE_HIGHZ:  op = OP_HIGHZ;
            default:     op = OP_BYPASS;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end

    // R2
    tlr_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_so,
    output tap_op_e    op
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_act;

    always_ff @(posedge tck) begin
        if (rst || state == ST_CAP_IR) ir_sh <= IR_CAPTURE_PAT;
        else if (state == ST_SH_IR)    ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction moves on the falling edge
    always_ff @(negedge tck) begin
        if (rst || state == ST_TLR) ir_act <= CODE_IDCODE;
        else if (state == ST_UPD_IR) ir_act <= ir_sh;
    end

    assign ir_so = ir_sh[0];
    assign op    = decode_op(ir_act);

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE_PAT));

    // R12
    ir_change_chk: assert property (@(posedge tck) disable iff (rst)
        !$stable(ir_act) |-> (state == ST_UPD_IR || state == ST_TLR));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3001
)(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    input  tap_op_e    op,
    input  logic       bsr_so,
    output logic       dr_so,
    output chain_ctl_t bsr_ctl
);

    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    logic            byp;
    logic [ID_W-1:0] id_sh;
    logic            sel_id, sel_chain, sel_byp;

    always_comb begin
        sel_id    = (op == OP_IDCODE);
        sel_chain = (op == OP_EXTEST) || (op == OP_SAMPLE);
        sel_byp   = !sel_id && !sel_chain;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp   <= 1'b0;
            id_sh <= ID_CAP;
        end else begin
            if (sel_byp && state == ST_CAP_DR)     byp <= 1'b0;
            else if (sel_byp && state == ST_SH_DR) byp <= tdi;
            if (sel_id && state == ST_CAP_DR)      id_sh <= ID_CAP;
            else if (sel_id && state == ST_SH_DR)  id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    always_comb begin
        bsr_ctl.capture = sel_chain && (state == ST_CAP_DR);
        bsr_ctl.shift   = sel_chain && (state == ST_SH_DR);
        bsr_ctl.update  = sel_chain && (state == ST_UPD_DR);
        if (sel_id)         dr_so = id_sh[0];
        else if (sel_chain) dr_so = bsr_so;
        else                dr_so = byp;
    end

    // R5
    byp_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (sel_byp && state == ST_CAP_DR) |=> !byp);

    // R9
    strobe_onehot_chk: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bsr_ctl.capture, bsr_ctl.shift, bsr_ctl.update}));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3001
)(
    input  logic tck,
    input  logic por,
    input  logic jtag_off,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic bsr_so,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic extest_mode,
    output logic pins_hiz,
    output logic pins_released
);

    logic       rst;
    tap_state_e state;
    tap_op_e    op;
    logic       ir_so, dr_so;
    chain_ctl_t bsr_ctl;

    assign rst = por | jtag_off;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck   (tck),
        .rst   (rst),
        .state (state),
        .tdi   (tdi),
        .ir_so (ir_so),
        .op    (op)
    );

    tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
        .tck     (tck),
        .rst     (rst),
        .state   (state),
        .tdi     (tdi),
        .op      (op),
        .bsr_so  (bsr_so),
        .dr_so   (dr_so),
        .bsr_ctl (bsr_ctl)
    );

    // Serial output launched on the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            if (state == ST_SH_IR)      tdo <= ir_so;
            else if (state == ST_SH_DR) tdo <= dr_so;
        end
    end

    assign bsr_capture   = bsr_ctl.capture;
    assign bsr_shift     = bsr_ctl.shift;
    assign bsr_update    = bsr_ctl.update;
    assign extest_mode   = !rst && (op == OP_EXTEST);
    assign pins_hiz      = !rst && (op == OP_HIGHZ);
    assign pins_released = jtag_off;

    // R10
    tdo_en_state_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R7
    hiz_no_chain_chk: assert property (@(posedge tck) disable iff (rst)
        pins_hiz |-> !(bsr_capture || bsr_shift || bsr_update));

endmodule

// File: tb/tb_jtag_tap_ctrl.sv
module tb_jtag_tap_ctrl;

    localparam int TCK_PERIOD = 20;
    localparam logic [31:0] ID = 32'h0A5C_3001;

    logic tck = 1'b0;
    logic por = 1'b1;
    logic jtag_off = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en, bsr_so, bsr_capture, bsr_shift, bsr_update;
    logic extest_mode, pins_hiz, pins_released;

    logic [7:0] chain = 8'h00;
    int upd_cnt = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        logic  v;
        string req;
    } exp_t;
    exp_t exp_q[$];

    jtag_tap_ctrl #(.ID_VALUE(ID)) dut (
        .tck(tck), .por(por), .jtag_off(jtag_off), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_so(bsr_so),
        .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
        .extest_mode(extest_mode), .pins_hiz(pins_hiz), .pins_released(pins_released)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    // Behavioural boundary chain: 8 cells, capture value A5
    always @(posedge tck) begin
        if (bsr_capture)    chain <= 8'hA5;
        else if (bsr_shift) chain <= {tdi, chain[7:1]};
        if (bsr_update)     upd_cnt <= upd_cnt + 1;
    end
    assign bsr_so = chain[0];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected bit per enabled falling-edge interval
    always @(negedge tck) begin
        #2;
        if (tdo_en === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R10", "tdo enabled with nothing to shift", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "tdo bit", {63'd0, tdo}, {63'd0, e.v});
            end
        end
    end

    // R10: tdo must not move on the rising edge
    always @(posedge tck) begin
        logic t0;
        t0 = tdo;
        #3;
        if (tdo_en === 1'b1) chk("R10", "tdo moved at rising edge", {63'd0, tdo}, {63'd0, t0});
    end

    task automatic clk_tms(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    // From Run-Test/Idle back to Run-Test/Idle
    task automatic scan_dr(input int n, input logic [63:0] din,
                           input logic [63:0] expv, input string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = expv[i];
            e.req = req;
            exp_q.push_back(e);
        end
        clk_tms(1, 0);
        clk_tms(0, 0);
        clk_tms(0, 0);
        for (int i = 0; i < n; i++) clk_tms(i == n - 1, din[i]);
        clk_tms(1, 0);
        clk_tms(0, 0);
        chk("R10", "bits left unshifted", exp_q.size(), 0);
    endtask

    task automatic scan_ir(input logic [3:0] code, input bit probe,
                           input logic hiz_old, input logic hiz_new);
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.v = (i == 0);
            e.req = "R3";
            exp_q.push_back(e);
        end
        clk_tms(1, 0);
        clk_tms(1, 0);
        clk_tms(0, 0);
        clk_tms(0, 0);
        for (int i = 0; i < 4; i++) clk_tms(i == 3, code[i]);
        clk_tms(1, 0);
        if (probe) begin
            chk("R12", "pins_hiz on entering Update-IR", {63'd0, pins_hiz}, {63'd0, hiz_old});
            @(negedge tck);
            #1;
            tms = 0;
            #1;
            chk("R12", "pins_hiz after falling edge", {63'd0, pins_hiz}, {63'd0, hiz_new});
            @(posedge tck);
            #1;
        end else begin
            clk_tms(0, 0);
        end
        chk("R10", "tdo_en in idle", {63'd0, tdo_en}, 0);
    endtask

    initial begin
        int u0;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #1;
        // R1
        chk("R1", "tdo_en in reset", {63'd0, tdo_en}, 0);
        chk("R1", "pins_hiz in reset", {63'd0, pins_hiz}, 0);
        chk("R1", "extest_mode in reset", {63'd0, extest_mode}, 0);
        chk("R1", "pins_released", {63'd0, pins_released}, 0);
        por = 0;
        clk_tms(0, 0);
        scan_dr(32, 64'd0, {32'd0, ID}, "R1");

        // R5
        scan_ir(4'b1111, 0, 0, 0);
        u0 = upd_cnt;
        scan_dr(8, 64'hB2, (64'hB2 << 1) & 64'hFF, "R5");
        chk("R9", "no update outside chain mode", upd_cnt, u0);

        // R6
        scan_ir(4'b0101, 0, 0, 0);
        scan_dr(8, 64'h3C, (64'h3C << 1) & 64'hFF, "R6");
        scan_ir(4'b1000, 0, 0, 0);
        scan_dr(5, 64'h17, (64'h17 << 1) & 64'h1F, "R6");

        // R7, R12
        scan_ir(4'b0011, 1, 0, 1);
        chk("R7", "pins_hiz under HIGHZ", {63'd0, pins_hiz}, 1);
        u0 = upd_cnt;
        scan_dr(6, 64'h2D, (64'h2D << 1) & 64'h3F, "R7");
        chk("R7", "no chain update under HIGHZ", upd_cnt, u0);

        // R2
        repeat (5) clk_tms(1, 0);
        clk_tms(0, 0);
        chk("R2", "pins_hiz after TMS reset", {63'd0, pins_hiz}, 0);
        scan_dr(32, 64'd0, {32'd0, ID}, "R2");

        // R8, R9 sample
        scan_ir(4'b0001, 0, 0, 0);
        chk("R8", "extest_mode under sample", {63'd0, extest_mode}, 0);
        u0 = upd_cnt;
        scan_dr(12, 64'h5C3, ((64'h5C3 & 64'hF) << 8) | 64'hA5, "R8");
        chk("R9", "one update per chain scan", upd_cnt, u0 + 1);

        // R8 external test
        scan_ir(4'b0000, 0, 0, 0);
        chk("R8", "extest_mode under external test", {63'd0, extest_mode}, 1);
        scan_dr(12, 64'h1E9, ((64'h1E9 & 64'hF) << 8) | 64'hA5, "R8");

        // R4
        scan_ir(4'b0010, 0, 0, 0);
        chk("R4", "extest_mode cleared", {63'd0, extest_mode}, 0);
        scan_dr(40, 64'hC5, (64'hC5 << 32) | {32'd0, ID}, "R4");

        // R11
        scan_ir(4'b0011, 0, 0, 0);
        chk("R11", "pins_hiz before disable", {63'd0, pins_hiz}, 1);
        @(negedge tck);
        #1;
        jtag_off = 1;
        clk_tms(0, 1);
        clk_tms(0, 0);
        clk_tms(0, 1);
        chk("R11", "pins_released", {63'd0, pins_released}, 1);
        chk("R11", "pins_hiz while disabled", {63'd0, pins_hiz}, 0);
        chk("R11", "tdo_en while disabled", {63'd0, tdo_en}, 0);
        chk("R11", "extest_mode while disabled", {63'd0, extest_mode}, 0);
        @(negedge tck);
        #1;
        jtag_off = 0;
        tms = 1;
        clk_tms(0, 0);
        chk("R11", "pins_released after enable", {63'd0, pins_released}, 0);
        scan_dr(32, 64'd0, {32'd0, ID}, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(TCK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule